// File: doc/BRIEF.md
# SCSI Controller Register File

This block is the host-facing register set of a small SCSI bus controller. A processor reaches it through a byte-wide synchronous port with a 4-bit register address. The block keeps a 24-bit transfer counter. Software writes a start value. A live copy counts down as the data engine moves bytes. The block also holds interrupt and status registers, three configuration bytes and a read-only view of the data FIFO fill level.

Writing the command register decodes the opcode into single-cycle strobes for the sequencer: FIFO flush, chip reset, bus reset, transfer, three selection variants, and enable or disable of reselection. Bit 7 of the command byte flags a DMA command, which reloads the live counter from the start value. The block drives a level interrupt line from the interrupt bit of its status register. Reading the interrupt register acknowledges it and lowers the line.

Reads return data on `rdata` one clock after `rd_en`. A write and a read never share a cycle: when `wr_en` is high, `rd_en` is ignored.

Top module: `scsi_ctl_regs`

## Register addresses and encodings

| Address | Register | Access |
|---|---|---|
| 0 | Count low byte | read / write |
| 1 | Count middle byte | read / write |
| 2 | Count high byte | read / write |
| 3 | Command | read / write |
| 4 | Status | read only |
| 5 | Interrupt | read only, cleared by the read |
| 6 | FIFO flags | read only |
| 7 | Configuration 1 | read / write |
| 8 | Configuration 2 | read / write |
| 9 | Configuration 3 | read / write |

Status register layout: bit 7 is the interrupt bit, bit 4 is terminal count, and bits 2:0 show the bus phase. All other status bits read as 0.

Configuration 1, bit 6, disables reporting of bus resets.

Interrupt register: bit 7 is the bus-reset interrupt.

## Requirements
- R1: After reset, `irq` is 0 and `cmd_strobe` is 0. Configuration 1 reads 7. The count high byte reads the chip ID (`CHIP_ID`, default 0x12). Every other register reads 0, except status bits 2:0, which show `bus_phase`.
- R2: A write to count address 0, 1 or 2 goes only to the start copy. Reads of addresses 0 to 2 return the live count, which stays unchanged until a DMA command is written.
- R3: A known command written with bit 7 set loads the live count from the start copy. A start copy of zero loads 0x010000 instead.
- R4: Each cycle with `dec_en` high lowers a nonzero live count by one; a zero count stays at zero. The step from 1 to 0 sets status bit 4 (terminal count).
- R5: A write to any of the three count bytes clears status bit 4.
- R6: The count high byte (address 2) reads `CHIP_ID` until it has been written once since the last reset. After that it reads live count bits 23:16.
- R7: A read of the interrupt register (address 5) returns its value. The same read clears the interrupt register, status bit 4 and status bit 7, and `irq` is low from the next cycle.
- R8: `irq` equals status bit 7. Raising an interrupt that is already pending changes nothing, and a single interrupt read clears it.
- R9: A read of address 6 returns `fifo_level`, zero-extended to 8 bits.
- R10: The bus-reset command (opcode 0x03) sets interrupt bit 7 and raises `irq`, unless configuration 1 bit 6 is set. In that case the interrupt register and `irq` stay unchanged.
- R11: Command bits 6:0 hold the opcode. A write of a known opcode stores the whole byte in the command register and, one cycle later, pulses one `cmd_strobe` bit for one cycle, with `cmd_dma` equal to bit 7. The opcode-to-strobe map is:
  - 0x01 → bit 0
  - 0x02 → bit 1
  - 0x03 → bit 2
  - 0x10 → bit 3
  - 0x41 → bit 4
  - 0x42 → bit 5
  - 0x43 → bit 6
  - 0x44 → bit 7
  - 0x45 → bit 8
  - 0x00 (no-op) is known but pulses no strobe.

  Any other opcode leaves all state unchanged (command register and live count included) and pulses nothing.
- R12: The reset command (opcode 0x02) returns every register to its R1 value, including the high-byte chip-ID behaviour, and still pulses `cmd_strobe` bit 1.
- R13: The enable-reselection command (0x44) clears the interrupt register. The disable-reselection command (0x45) clears it and raises `irq`.
- R14: Status bits 2:0 return the value of `bus_phase` sampled in the read cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe, ignored while wr_en is high |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid the cycle after rd_en |
| bus_phase | input | 3 | Current bus phase from the sequencer |
| fifo_level | input | 5 | Data FIFO fill level |
| dec_en | input | 1 | One byte moved; decrement the live count |
| irq | output | 1 | Level interrupt request |
| cmd_strobe | output | 9 | One-hot command pulses |
| cmd_dma | output | 1 | DMA flag of the pulsed command |

## Verification
The properties assume one register access per cycle. They also assume that `dec_en` is never high in the same cycle as an interrupt-register read, because then the two updates of the terminal-count bit would collide. The bench drives every access in its own cycle at the falling edge and pulses `dec_en` only in cycles with no access. It reads back status and counts between steps, so no decrement coincides with an acknowledge.

// File: rtl/scsi_regs_pkg.sv
package scsi_regs_pkg;

  localparam int REG_AW   = 4;
  localparam int REG_DW   = 8;
  localparam int NUM_CMDS = 9;

  typedef enum logic [REG_AW-1:0] {
    RA_CNT_LO  = 4'd0,
    RA_CNT_MID = 4'd1,
    RA_CNT_HI  = 4'd2,
    RA_CMD     = 4'd3,
    RA_STATUS  = 4'd4,
    RA_INTR    = 4'd5,
    RA_FLAGS   = 4'd6,
    RA_CFG1    = 4'd7,
    RA_CFG2    = 4'd8,
    RA_CFG3    = 4'd9
  } reg_addr_e;

  // command opcodes, bits 6:0 of the command byte
  localparam logic [6:0] OP_NOP      = 7'h00;
  localparam logic [6:0] OP_FLUSH    = 7'h01;
  localparam logic [6:0] OP_RESET    = 7'h02;
  localparam logic [6:0] OP_BUSRST   = 7'h03;
  localparam logic [6:0] OP_XFER     = 7'h10;
  localparam logic [6:0] OP_SEL      = 7'h41;
  localparam logic [6:0] OP_SELATN   = 7'h42;
  localparam logic [6:0] OP_SELSTOP  = 7'h43;
  localparam logic [6:0] OP_RESEL_EN = 7'h44;
  localparam logic [6:0] OP_RESEL_DI = 7'h45;

  // strobe positions
  localparam int SI_FLUSH    = 0;
  localparam int SI_RESET    = 1;
  localparam int SI_BUSRST   = 2;
  localparam int SI_XFER     = 3;
  localparam int SI_SEL      = 4;
  localparam int SI_SELATN   = 5;
  localparam int SI_SELSTOP  = 6;
  localparam int SI_RESEL_EN = 7;
  localparam int SI_RESEL_DI = 8;

  localparam int DMA_BIT         = 7;
  localparam int STAT_INT_BIT    = 7;
  localparam int STAT_TC_BIT     = 4;
  localparam int PHASE_W         = 3;
  localparam int INTR_BUSRST_BIT = 7;
  localparam int CFG1_NOREP_BIT  = 6;

endpackage

// File: rtl/scsi_cmd_decode.sv
module scsi_cmd_decode
  import scsi_regs_pkg::*;
#(
  parameter int NCMD = NUM_CMDS
) (
  input  logic [6:0]      opcode,
  output logic            known,
  output logic [NCMD-1:0] onehot
);

  always_comb begin
    known  = 1'b1;
    onehot = '0;
    case (opcode)
      OP_NOP:      ;
      OP_FLUSH:    onehot[SI_FLUSH]    = 1'b1;
      OP_RESET:    onehot[SI_RESET]    = 1'b1;
      OP_BUSRST:   onehot[SI_BUSRST]   = 1'b1;
      OP_XFER:     onehot[SI_XFER]     = 1'b1;
      OP_SEL:      onehot[SI_SEL]      = 1'b1;
      OP_SELATN:   onehot[SI_SELATN]   = 1'b1;
      OP_SELSTOP:  onehot[SI_SELSTOP]  = 1'b1;
      OP_RESEL_EN: onehot[SI_RESEL_EN] = 1'b1;
      OP_RESEL_DI: onehot[SI_RESEL_DI] = 1'b1;
      default:     known = 1'b0;
    endcase
  end

endmodule

// File: rtl/scsi_xfer_counter.sv
module scsi_xfer_counter #(
  parameter int CNT_W       = 24,
  parameter int BYTE_W      = 8,
  parameter int ZERO_RELOAD = 'h10000
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [CNT_W/BYTE_W-1:0] byte_we,
  input  logic [BYTE_W-1:0]     wdata,
  input  logic                  load,
  input  logic                  dec,
  output logic [CNT_W-1:0]      live,
  output logic [CNT_W-1:0]      start,
  output logic                  hi_written,
  output logic                  zero_hit
);

  localparam int NB = CNT_W / BYTE_W;
  localparam logic [CNT_W-1:0] RELOAD = CNT_W'(ZERO_RELOAD);

  always_ff @(posedge clk) begin
    if (rst) begin
      start <= '0;
    end else begin
      for (int b = 0; b < NB; b++) begin
        if (byte_we[b]) start[b*BYTE_W +: BYTE_W] <= wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                  hi_written <= 1'b0;
    else if (byte_we[NB-1])   hi_written <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)                      live <= '0;
    else if (load)                live <= (start == '0) ? RELOAD : start;
    else if (dec && live != '0)   live <= live - 1'b1;
  end

  assign zero_hit = dec && !load && (live == CNT_W'(1));

endmodule

// File: rtl/scsi_irq_status.sv
module scsi_irq_status #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] intr_or,
  input  logic          intr_clr,
  input  logic          raise,
  input  logic          rd_clear,
  input  logic          tc_set,
  input  logic          tc_clr,
  output logic [DW-1:0] intr_q,
  output logic          int_q,
  output logic          tc_q
);

  always_ff @(posedge clk) begin
    if (rst) intr_q <= '0;
    else     intr_q <= ((rd_clear || intr_clr) ? '0 : intr_q) | intr_or;
  end

  // a raise while already pending leaves the bit as it is
  always_ff @(posedge clk) begin
    if (rst)           int_q <= 1'b0;
    else if (raise)    int_q <= 1'b1;
    else if (rd_clear) int_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst)                    tc_q <= 1'b0;
    else if (tc_set)            tc_q <= 1'b1;
    else if (tc_clr || rd_clear) tc_q <= 1'b0;
  end

endmodule

// File: rtl/scsi_ctl_regs.sv
module scsi_ctl_regs
  import scsi_regs_pkg::*;
#(
  parameter int           CNT_W      = 24,
  parameter int           FIFO_CNT_W = 5,
  parameter logic [7:0]   CHIP_ID    = 8'h12,
  parameter logic [7:0]   CFG1_INIT  = 8'h07
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic                  rd_en,
  input  logic [REG_AW-1:0]     addr,
  input  logic [REG_DW-1:0]     wdata,
  output logic [REG_DW-1:0]     rdata,
  input  logic [PHASE_W-1:0]    bus_phase,
  input  logic [FIFO_CNT_W-1:0] fifo_level,
  input  logic                  dec_en,
  output logic                  irq,
  output logic [NUM_CMDS-1:0]   cmd_strobe,
  output logic                  cmd_dma
);

  localparam int NB = CNT_W / REG_DW;

  logic                 wr_cmd, rd_ok, known, soft_rst, rst_any;
  logic [NUM_CMDS-1:0]  dec_onehot;
  logic [NB-1:0]        byte_we;
  logic                 cnt_load, cnt_wr, zero_hit, hi_written;
  logic [CNT_W-1:0]     live_cnt, start_cnt;
  logic [REG_DW-1:0]    intr_or, intr_q, status_v;
  logic                 busrst_go, intr_clr, raise, rd_clear, int_q, tc_q;
  logic [REG_DW-1:0]    cmd_q, cfg1_q, cfg2_q, cfg3_q;

  assign wr_cmd = wr_en && (addr == RA_CMD);
  assign rd_ok  = rd_en && !wr_en;

  scsi_cmd_decode #(.NCMD(NUM_CMDS)) u_dec (
    .opcode (wdata[6:0]),
    .known  (known),
    .onehot (dec_onehot)
  );

  assign soft_rst = wr_cmd && dec_onehot[SI_RESET];
  assign rst_any  = rst || soft_rst;

  for (genvar b = 0; b < NB; b++) begin : g_bwe
    assign byte_we[b] = wr_en && (addr == REG_AW'(b));
  end

  assign cnt_wr   = |byte_we;
  assign cnt_load = wr_cmd && known && wdata[DMA_BIT];

  scsi_xfer_counter #(.CNT_W(CNT_W), .BYTE_W(REG_DW)) u_cnt (
    .clk        (clk),
    .rst        (rst_any),
    .byte_we    (byte_we),
    .wdata      (wdata),
    .load       (cnt_load),
    .dec        (dec_en),
    .live       (live_cnt),
    .start      (start_cnt),
    .hi_written (hi_written),
    .zero_hit   (zero_hit)
  );

  assign busrst_go = wr_cmd && dec_onehot[SI_BUSRST] && !cfg1_q[CFG1_NOREP_BIT];
  assign intr_clr  = wr_cmd && (dec_onehot[SI_RESEL_EN] || dec_onehot[SI_RESEL_DI]);
  assign raise     = busrst_go || (wr_cmd && dec_onehot[SI_RESEL_DI]);
  assign rd_clear  = rd_ok && (addr == RA_INTR);

  always_comb begin
    intr_or = '0;
    intr_or[INTR_BUSRST_BIT] = busrst_go;
  end

  scsi_irq_status #(.DW(REG_DW)) u_irq (
    .clk      (clk),
    .rst      (rst_any),
    .intr_or  (intr_or),
    .intr_clr (intr_clr),
    .raise    (raise),
    .rd_clear (rd_clear),
    .tc_set   (zero_hit),
    .tc_clr   (cnt_wr),
    .intr_q   (intr_q),
    .int_q    (int_q),
    .tc_q     (tc_q)
  );

  assign irq = int_q;

  always_ff @(posedge clk) begin
    if (rst_any) begin
      cmd_q  <= '0;
      cfg1_q <= CFG1_INIT;
      cfg2_q <= '0;
      cfg3_q <= '0;
    end else if (wr_en) begin
      case (addr)
        RA_CMD:  if (known) cmd_q <= wdata;
        RA_CFG1: cfg1_q <= wdata;
        RA_CFG2: cfg2_q <= wdata;
        RA_CFG3: cfg3_q <= wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_strobe <= '0;
      cmd_dma    <= 1'b0;
    end else begin
      cmd_strobe <= wr_cmd ? dec_onehot : '0;
      cmd_dma    <= wr_cmd && known && wdata[DMA_BIT];
    end
  end

  always_comb begin
    status_v = '0;
    status_v[PHASE_W-1:0]  = bus_phase;
    status_v[STAT_TC_BIT]  = tc_q;
    status_v[STAT_INT_BIT] = int_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_ok) begin
      if (int'(addr) < NB) begin
        if (int'(addr) == NB - 1 && !hi_written) rdata <= CHIP_ID;
        else rdata <= live_cnt[int'(addr)*REG_DW +: REG_DW];
      end else begin
        case (addr)
          RA_CMD:    rdata <= cmd_q;
          RA_STATUS: rdata <= status_v;
          RA_INTR:   rdata <= intr_q;
          RA_FLAGS:  rdata <= REG_DW'(fifo_level);
          RA_CFG1:   rdata <= cfg1_q;
          RA_CFG2:   rdata <= cfg2_q;
          RA_CFG3:   rdata <= cfg3_q;
          default:   rdata <= '0;
        endcase
      end
    end
  end

endmodule

// File: rtl/scsi_ctl_regs_chk.sv
module scsi_ctl_regs_chk
  import scsi_regs_pkg::*;
#(
  parameter int NCMD  = NUM_CMDS,
  parameter int CW    = 24
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic              rd_en,
  input logic [REG_AW-1:0] addr,
  input logic [REG_DW-1:0] wdata,
  input logic              irq,
  input logic [NCMD-1:0]   cmd_strobe,
  input logic [REG_DW-1:0] cfg1_q,
  input logic [CW-1:0]     live_cnt,
  input logic              dec_en,
  input logic              cnt_load
);

  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (!irq && cmd_strobe == '0));

  p_dec_floor_r4: assert property (@(posedge clk) disable iff (rst)
    (live_cnt == '0 && dec_en && !cnt_load) |=> live_cnt == '0);

  p_ack_lowers_r7: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !wr_en && addr == RA_INTR) |=> !irq);

  p_rise_source_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(wr_en && addr == RA_CMD));

  p_busrst_raise_r10: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == RA_CMD && wdata[6:0] == OP_BUSRST && !cfg1_q[CFG1_NOREP_BIT])
    |=> irq);

  p_strobe_onehot_r11: assert property (@(posedge clk) disable iff (rst)
    $onehot0(cmd_strobe));

  p_strobe_cause_r11: assert property (@(posedge clk) disable iff (rst)
    (|cmd_strobe) |-> $past(wr_en && addr == RA_CMD));

endmodule

bind scsi_ctl_regs scsi_ctl_regs_chk #(.NCMD(NUM_CMDS), .CW(CNT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .wr_en      (wr_en),
  .rd_en      (rd_en),
  .addr       (addr),
  .wdata      (wdata),
  .irq        (irq),
  .cmd_strobe (cmd_strobe),
  .cfg1_q     (cfg1_q),
  .live_cnt   (live_cnt),
  .dec_en     (dec_en),
  .cnt_load   (cnt_load)
);

// File: tb/scsi_ctl_regs_tb.sv
`timescale 1ns/1ps
module scsi_ctl_regs_tb;

  localparam logic [7:0] ID = 8'h12;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0, rd_en = 1'b0, dec_en = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [2:0] bus_phase = '0;
  logic [4:0] fifo_level = '0;
  logic       irq, cmd_dma;
  logic [8:0] cmd_strobe;

  int tests = 0, fails = 0, cyc = 0;
  bit done = 0;
  logic [8:0] last_strobe;
  logic       last_dma;
  logic [7:0] v;

  always #2.5 clk = ~clk;

  scsi_ctl_regs u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .bus_phase(bus_phase),
    .fifo_level(fifo_level), .dec_en(dec_en), .irq(irq),
    .cmd_strobe(cmd_strobe), .cmd_dma(cmd_dma)
  );

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
    last_strobe = cmd_strobe; last_dma = cmd_dma;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic dec1();
    @(negedge clk); dec_en = 1'b1;
    @(negedge clk); dec_en = 1'b0;
  endtask

  task automatic chk_live(input string req, input int exp);
    logic [7:0] l, m, h;
    rd(4'd0, l); rd(4'd1, m); rd(4'd2, h);
    check(req, {h, m, l}, exp);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 60000 && !done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [6:0] ops [10];
    int         idx [10];
    ops = '{7'h00, 7'h01, 7'h02, 7'h03, 7'h10, 7'h41, 7'h42, 7'h43, 7'h44, 7'h45};
    idx = '{-1, 0, 1, 2, 3, 4, 5, 6, 7, 8};

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check("R1 irq", irq, 0);
    check("R1 strobe", cmd_strobe, 0);
    rd(4'd7, v); check("R1 cfg1", v, 8'h07);
    rd(4'd2, v); check("R1 R6 chip id", v, ID);
    for (int a = 0; a < 16; a++) begin
      if (a != 2 && a != 7) begin
        rd(4'(a), v); check("R1 register zero", v, 0);
      end
    end

    // R2 start copy only
    wr(4'd0, 8'h34); wr(4'd1, 8'h12); wr(4'd2, 8'h00);
    chk_live("R2 live unchanged", 0);
    // R3 load
    wr(4'd3, 8'h80);
    check("R11 nop no strobe", last_strobe, 0);
    chk_live("R3 load", 24'h001234);
    // R3 zero start sweep
    for (int i = 0; i < 12; i++) begin
      int sv;
      sv = (i == 0) ? 0 : ((i * 24'h0B3A71) & 24'hFFFFFF);
      wr(4'd0, sv[7:0]); wr(4'd1, sv[15:8]); wr(4'd2, sv[23:16]);
      wr(4'd3, 8'h90);
      chk_live("R3 reload sweep", (sv == 0) ? 24'h010000 : sv);
      rd(4'd0, v);
    end

    // R4 decrement to zero
    wr(4'd0, 8'h03); wr(4'd1, 8'h00); wr(4'd2, 8'h00); wr(4'd3, 8'h80);
    rd(4'd4, v); check("R4 tc clear before", v & 8'h10, 0);
    for (int k = 2; k >= 0; k--) begin
      dec1(); chk_live("R4 dec", k);
    end
    rd(4'd4, v); check("R4 tc set", v, 8'h10);
    dec1(); chk_live("R4 saturate", 0);
    // R5
    wr(4'd1, 8'h00);
    rd(4'd4, v); check("R5 tc cleared", v, 0);

    // R7 R10 bus reset and ack
    wr(4'd3, 8'h03);
    check("R10 irq", irq, 1);
    check("R11 busrst strobe", last_strobe, 9'h004);
    @(negedge clk);
    check("R11 single pulse", cmd_strobe, 0);
    rd(4'd4, v); check("R8 status int", v, 8'h80);
    wr(4'd3, 8'h03);
    check("R8 still raised", irq, 1);
    rd(4'd5, v); check("R7 intr value", v, 8'h80);
    check("R7 irq low", irq, 0);
    rd(4'd5, v); check("R7 intr cleared", v, 0);
    rd(4'd4, v); check("R7 status cleared", v, 0);
    // R7 clears TC
    wr(4'd0, 8'h01); wr(4'd2, 8'h00); wr(4'd3, 8'h80); dec1();
    rd(4'd4, v); check("R4 tc again", v, 8'h10);
    rd(4'd5, v); rd(4'd4, v); check("R7 tc cleared", v, 0);

    // R10 suppressed
    wr(4'd7, 8'h47);
    wr(4'd3, 8'h03);
    check("R10 no irq", irq, 0);
    check("R11 strobe when suppressed", last_strobe, 9'h004);
    rd(4'd5, v); check("R10 intr untouched", v, 0);
    wr(4'd7, 8'h07);

    // R13
    wr(4'd3, 8'h03); wr(4'd3, 8'h44);
    rd(4'd4, v); check("R13 enable keeps int", v & 8'h80, 8'h80);
    rd(4'd5, v); check("R13 enable clears intr", v, 0);
    wr(4'd3, 8'h03); wr(4'd3, 8'h45);
    check("R13 disable raises", irq, 1);
    rd(4'd5, v); check("R13 disable clears intr", v, 0);

    // R9 sweep
    for (int f = 0; f < 32; f++) begin
      fifo_level = 5'(f); rd(4'd6, v); check("R9 fifo flags", v, f);
    end
    // R14 sweep
    for (int p = 0; p < 8; p++) begin
      bus_phase = 3'(p); rd(4'd4, v); check("R14 phase", v, p);
    end
    bus_phase = '0;

    // R11 command sweep
    for (int i = 0; i < 10; i++) begin
      for (int d = 0; d < 2; d++) begin
        wr(4'd3, {d[0], ops[i]});
        check("R11 strobe", last_strobe, (idx[i] < 0) ? 0 : (1 << idx[i]));
        check("R11 dma flag", last_dma, d);
        if (idx[i] != 1) begin
          rd(4'd3, v); check("R11 cmd readback", v, {d[0], ops[i]});
        end
        rd(4'd5, v);
      end
    end
    // R11 unknown opcode
    wr(4'd0, 8'h22); wr(4'd1, 8'h00); wr(4'd2, 8'h00); wr(4'd3, 8'h80);
    wr(4'd0, 8'h77);
    wr(4'd3, 8'hFF);
    check("R11 unknown no strobe", last_strobe, 0);
    check("R11 unknown no dma", last_dma, 0);
    rd(4'd3, v); check("R11 unknown keeps cmd", v, 8'h80);
    chk_live("R11 unknown no reload", 24'h000022);

    // R12 reset command
    wr(4'd8, 8'h55); wr(4'd9, 8'hAA); wr(4'd7, 8'h41); wr(4'd3, 8'h03);
    wr(4'd3, 8'h02);
    check("R12 strobe", last_strobe, 9'h002);
    check("R12 irq", irq, 0);
    rd(4'd8, v); check("R12 cfg2", v, 0);
    rd(4'd9, v); check("R12 cfg3", v, 0);
    rd(4'd7, v); check("R12 cfg1", v, 8'h07);
    rd(4'd2, v); check("R12 R6 chip id back", v, ID);
    rd(4'd0, v); check("R12 live zero", v, 0);
    rd(4'd5, v); check("R12 intr zero", v, 0);
    rd(4'd3, v); check("R12 cmd zero", v, 0);
    wr(4'd2, 8'h00);
    rd(4'd2, v); check("R6 live high after write", v, 0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule